// File: doc/BRIEF.md
# Address-Range Cache Maintenance Sequencer

This block turns one maintenance request over a byte range into the line-by-line commands a cache controller needs. A request carries a start address, an exclusive end address and an operation: invalidate, clean, or clean-and-invalidate. The sequencer walks the 32-byte lines that the range touches. For each line it issues one or two address-based commands on a command handshake. It then waits for an external barrier to complete and pulses `done`.

For an invalidate, a line that the range covers only in part would lose neighbouring dirty data. Such a head or tail line therefore gets a clean command first, then an invalidate. Lines that lie wholly inside the range get an invalidate only.

A request for invalidate or clean-and-invalidate that spans the entire address space, from zero to all-ones, is not walked. It goes out as a single whole-cache request that the cache controller carries out by set and way. Address translation and the cache arrays themselves live outside this block.

Top module: `cmo_range_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `cmd_valid`, `all_valid`, `bar_req` and `done` are 0.
- R2: Operation code 1 (clean) issues one command with code 0 (clean) per line. The first line is at start aligned down to 32. The address then steps by 32 while it is below end. A clean over the full address space is walked like this and is never diverted.
- R3: Operation codes 2 and 3 (clean-and-invalidate) walk the same lines as R2. Each line gets a clean command (code 0) immediately followed by an invalidate command (code 1) at the same address.
- R4: Operation code 0 (invalidate) works as follows. If start is not 32-aligned, its containing line gets clean then invalidate, and the walk continues at the next line boundary. Every following line that lies below end aligned down to 32 gets one invalidate command (code 1) only.
- R5: For invalidate, a partial line left after the full lines, while the address is still below end, gets clean then invalidate. When start and end fall in the same partial line, only the head pair is issued.
- R6: Operation 0, 2 or 3 with start 0 and end all-ones (every bit of the `ADDR_W`-bit address set) issues no line commands. It raises `all_valid` instead, with `all_code` 0 for invalidate and 1 for clean-and-invalidate. `all_valid` is held until `all_ack`.
- R7: A request with end less than or equal to start issues no line or whole-cache command but still performs the barrier and signals `done`.
- R8: `bar_req` rises only after the last command or whole-cache request has been accepted. It is held until `bar_ack`. `done` is a one-cycle pulse in the cycle after the barrier handshake. `req_ready` is 0 from acceptance until after that pulse.
- R9: Every issued line address has its low 5 bits zero. While `cmd_valid` is high and `cmd_ready` is low, `cmd_addr` and `cmd_code` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Exclusive end address of the range |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 clean-and-invalidate |
| cmd_valid | output | 1 | Line command offered |
| cmd_ready | input | 1 | Line command accepted |
| cmd_addr | output | ADDR_W | Line-aligned address |
| cmd_code | output | 1 | 0 clean, 1 invalidate |
| all_valid | output | 1 | Whole-cache request |
| all_ack | input | 1 | Whole-cache request accepted |
| all_code | output | 1 | 0 invalidate all, 1 clean-and-invalidate all |
| bar_req | output | 1 | Barrier requested |
| bar_ack | input | 1 | Barrier complete |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps start and end over a grid that crosses line boundaries in every alignment, for every operation, with irregular back-pressure on each handshake. Each sweep case is compared against an arithmetic model of the command list.

The sweep targets the following cases, each with the fault it would expose:
- Ranges that start and end inside one line, where a design that re-tests the tail after the head would emit a duplicate pair.
- Aligned starts and ends, where an off-by-one in the interior bound would turn an invalidate into a pair or drop the last line.
- Ranges ending at all-ones near the top, where a cursor without a carry bit would wrap to zero and loop.
- The full-space request for each operation, where a design that diverts clean would skip 32 line cleans.
- Empty ranges, where a design that skips the barrier would never reach `done`.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

  typedef enum logic [1:0] {
    OP_INV       = 2'd0,
    OP_CLEAN     = 2'd1,
    OP_FLUSH     = 2'd2,
    OP_FLUSH_ALT = 2'd3
  } op_e;

  // per-line treatment
  typedef enum logic [1:0] {
    K_CLEAN = 2'd0,
    K_INV   = 2'd1,
    K_PAIR  = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LINE  = 3'd1,
    S_WHOLE = 3'd2,
    S_BAR   = 3'd3,
    S_DONE  = 3'd4
  } state_e;

  localparam logic CMD_CLEAN = 1'b0;
  localparam logic CMD_INV   = 1'b1;

endpackage

// File: rtl/cmo_rst_sync.sv
module cmo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/cmo_req_classify.sv
module cmo_req_classify
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 5
) (
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] end_a,
  input  op_e               op,
  output logic              is_empty,
  output logic              is_whole,
  output logic              head_split,
  output logic [ADDR_W:0]   first_line
);
  assign is_empty   = (end_a <= start_a);
  assign is_whole   = (op != OP_CLEAN) && (start_a == '0) && (&end_a);
  assign head_split = (op == OP_INV) && (|start_a[LINE_SHIFT-1:0]);
  assign first_line = {1'b0, start_a[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
endmodule

// File: rtl/cmo_line_kind.sv
module cmo_line_kind
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 5
) (
  input  op_e             op,
  input  logic            head,
  input  logic [ADDR_W:0] cur,
  input  logic [ADDR_W:0] end_x,
  output kind_e           kind,
  output logic [ADDR_W:0] next_line,
  output logic            more
);
  localparam logic [ADDR_W:0] LINE_STEP = (ADDR_W+1)'(1) << LINE_SHIFT;

  assign next_line = cur + LINE_STEP;
  assign more      = (next_line < end_x);

  always_comb begin
    unique case (op)
      OP_CLEAN: kind = K_CLEAN;
      OP_INV: begin
        if (head)                     kind = K_PAIR;
        else if (next_line <= end_x)  kind = K_INV;
        else                          kind = K_PAIR;
      end
      default:  kind = K_PAIR;
    endcase
  end
endmodule

// File: rtl/cmo_range_seq.sv
module cmo_range_seq
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [1:0]        req_op,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_code,
  output logic              all_valid,
  input  logic              all_ack,
  output logic              all_code,
  output logic              bar_req,
  input  logic              bar_ack,
  output logic              done
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);

  logic rst_n_s;
  cmo_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  state_e          st_q, st_d;
  logic [ADDR_W:0] cur_q, cur_d;
  logic [ADDR_W:0] end_q, end_d;
  op_e             op_q, op_d;
  logic            head_q, head_d;
  logic            sec_q, sec_d;
  logic            dp_en;

  op_e             op_in;
  logic            c_empty, c_whole, c_head;
  logic [ADDR_W:0] c_first;
  kind_e           kind;
  logic [ADDR_W:0] next_line;
  logic            more;

  assign op_in = op_e'(req_op);

  cmo_req_classify #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)) u_cls (
    .start_a(req_start), .end_a(req_end), .op(op_in),
    .is_empty(c_empty), .is_whole(c_whole), .head_split(c_head), .first_line(c_first)
  );

  cmo_line_kind #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)) u_kind (
    .op(op_q), .head(head_q), .cur(cur_q), .end_x(end_q),
    .kind(kind), .next_line(next_line), .more(more)
  );

  // next-state
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    end_d  = end_q;
    op_d   = op_q;
    head_d = head_q;
    sec_d  = sec_q;
    dp_en  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          dp_en  = 1'b1;
          op_d   = op_in;
          end_d  = {1'b0, req_end};
          cur_d  = c_first;
          head_d = c_head;
          sec_d  = 1'b0;
          if (c_empty)      st_d = S_BAR;
          else if (c_whole) st_d = S_WHOLE;
          else              st_d = S_LINE;
        end
      end
      S_LINE: begin
        if (cmd_ready) begin
          dp_en = 1'b1;
          if (kind == K_PAIR && !sec_q) begin
            sec_d = 1'b1;
          end else begin
            sec_d  = 1'b0;
            head_d = 1'b0;
            cur_d  = next_line;
            if (!more) st_d = S_BAR;
          end
        end
      end
      S_WHOLE: if (all_ack) st_d = S_BAR;
      S_BAR:   if (bar_ack) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= S_IDLE;
    else          st_q <= st_d;
  end

  // datapath registers, enabled, no reset
  always_ff @(posedge clk) begin
    if (dp_en) begin
      cur_q  <= cur_d;
      end_q  <= end_d;
      op_q   <= op_d;
      head_q <= head_d;
      sec_q  <= sec_d;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign cmd_valid = (st_q == S_LINE);
  assign cmd_addr  = cur_q[ADDR_W-1:0];
  assign cmd_code  = ((kind == K_INV) || (kind == K_PAIR && sec_q)) ? CMD_INV : CMD_CLEAN;
  assign all_valid = (st_q == S_WHOLE);
  assign all_code  = (op_q == OP_INV) ? 1'b0 : 1'b1;
  assign bar_req   = (st_q == S_BAR);
  assign done      = (st_q == S_DONE);
endmodule

// File: rtl/cmo_range_seq_chk.sv
module cmo_range_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_code,
  input logic              all_valid,
  input logic              all_ack,
  input logic              all_code,
  input logic              bar_req,
  input logic              bar_ack,
  input logic              done
);
  localparam int LS = $clog2(LINE_BYTES);

  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[LS-1:0] == '0));

  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_code)));

  a_r6_whole_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (all_valid && !all_ack) |=> (all_valid && $stable(all_code)));

  a_r8_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_req && !bar_ack) |=> bar_req);

  a_r8_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, all_valid, bar_req, done}));

  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || all_valid || bar_req || done) |-> !req_ready);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_bar: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bar_req && bar_ack));
endmodule

bind cmo_range_seq cmo_range_seq_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_code(cmd_code),
  .all_valid(all_valid), .all_ack(all_ack), .all_code(all_code),
  .bar_req(bar_req), .bar_ack(bar_ack), .done(done)
);

// File: tb/cmo_range_seq_test.sv
module cmo_range_seq_test;
  localparam int AW  = 10;
  localparam int TOP = (1 << AW) - 1;

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [AW-1:0] req_start, req_end;
  logic [1:0] req_op;
  logic cmd_valid, cmd_ready, cmd_code;
  logic [AW-1:0] cmd_addr;
  logic all_valid, all_ack, all_code;
  logic bar_req, bar_ack, done;

  cmo_range_seq #(.ADDR_W(AW), .LINE_BYTES(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .req_op(req_op),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_code(cmd_code),
    .all_valid(all_valid), .all_ack(all_ack), .all_code(all_code),
    .bar_req(bar_req), .bar_ack(bar_ack), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int wd = 0;

  int exp_a [0:255];
  int exp_c [0:255];
  int n_exp;
  bit exp_whole;
  int exp_wcode;
  int got_a [0:255];
  int got_c [0:255];

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", wd);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input int a, input int c);
    exp_a[n_exp] = a;
    exp_c[n_exp] = c;
    n_exp++;
  endtask

  // arithmetic model of the command list
  task automatic build_exp(input int s, input int e, input int op);
    int a;
    n_exp = 0; exp_whole = 0; exp_wcode = 0;
    if (e <= s) return;
    if (op != 1 && s == 0 && e == TOP) begin
      exp_whole = 1;
      exp_wcode = (op == 0) ? 0 : 1;
      return;
    end
    if (op == 1) begin
      a = s & ~31;
      while (a < e) begin push(a, 0); a += 32; end
    end else if (op >= 2) begin
      a = s & ~31;
      while (a < e) begin push(a, 0); push(a, 1); a += 32; end
    end else begin
      a = s;
      if ((s & 31) != 0) begin
        push(s & ~31, 0); push(s & ~31, 1);
        a = (s | 31) + 1;
      end
      while (a < (e & ~31)) begin push(a, 1); a += 32; end
      if (a < e) begin push(a, 0); push(a, 1); end
    end
  endtask

  task automatic run_req(input int s, input int e, input int op, input string tag);
    int n_got, cyc, mism, first_bad, wcode;
    bit fin, whole_seen, stall_bad, early, busy_bad, bar_hs, pend, ok;
    logic [AW-1:0] pa;
    logic pc;
    build_exp(s, e, op);
    @(negedge clk);
    req_start = AW'(s); req_end = AW'(e); req_op = 2'(op); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n_got = 0; cyc = 0; fin = 0; whole_seen = 0; wcode = -1;
    stall_bad = 0; early = 0; busy_bad = 0; bar_hs = 0; pend = 0;
    pa = '0; pc = 1'b0;
    while (!fin && cyc < 4000) begin
      cmd_ready = ((cyc % 4) != 2);
      all_ack   = all_valid && ((cyc % 2) == 1);
      bar_ack   = bar_req && ((cyc % 3) == 0);
      if (pend && (!cmd_valid || cmd_addr != pa || cmd_code != pc)) stall_bad = 1;
      pend = cmd_valid && !cmd_ready;
      pa = cmd_addr; pc = cmd_code;
      if (cmd_valid && cmd_ready) begin
        if (n_got < 256) begin got_a[n_got] = int'(cmd_addr); got_c[n_got] = int'(cmd_code); end
        n_got++;
      end
      if (all_valid && all_ack) begin whole_seen = 1; wcode = int'(all_code); end
      if (bar_req && (n_got != n_exp || whole_seen != exp_whole)) early = 1;
      if (bar_req && bar_ack) bar_hs = 1;
      if (done) fin = 1;
      else if (req_ready) busy_bad = 1;
      if (!fin) begin @(negedge clk); cyc++; end
    end
    cmd_ready = 1'b0; all_ack = 1'b0; bar_ack = 1'b0;
    mism = 0; first_bad = -1;
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      if (got_a[i] != exp_a[i] || got_c[i] != exp_c[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    check(n_got == n_exp && mism == 0, tag,
          $sformatf("cmd list s=%0d e=%0d op=%0d first_bad=%0d count", s, e, op, first_bad),
          n_got, n_exp);
    if (exp_whole || whole_seen)
      check(whole_seen == exp_whole && wcode == exp_wcode, "R6",
            $sformatf("whole-cache code s=%0d e=%0d op=%0d", s, e, op), wcode, exp_wcode);
    check(fin && bar_hs && !early && !busy_bad, "R8",
          $sformatf("barrier/done order s=%0d e=%0d op=%0d", s, e, op),
          {fin, bar_hs, early, busy_bad}, 4'b1100);
    check(!stall_bad, "R9", $sformatf("hold under stall s=%0d e=%0d", s, e), stall_bad, 0);
    @(negedge clk);
    check(!done && req_ready, "R8", "done single pulse then idle", {done, req_ready}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_start = '0; req_end = '0; req_op = '0;
    cmd_ready = 1'b0; all_ack = 1'b0; bar_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !cmd_valid && !all_valid && !bar_req && !done, "R1", "reset state",
          {req_ready, cmd_valid, all_valid, bar_req, done}, 5'b10000);

    // R6: whole-space diversion, and R2: clean over whole space is walked
    run_req(0, TOP, 0, "R6");
    run_req(0, TOP, 2, "R6");
    run_req(0, TOP, 3, "R6");
    run_req(0, TOP, 1, "R2");
    // R7: empty ranges
    run_req(40, 40, 0, "R7");
    run_req(100, 37, 1, "R7");
    run_req(64, 0, 2, "R7");
    // R5: same partial line, tails near top
    run_req(33, 40, 0, "R5");
    run_req(33, 70, 0, "R5");
    run_req(990, TOP, 0, "R5");
    run_req(960, TOP, 2, "R3");
    run_req(992, TOP, 1, "R2");
    // sweeps
    for (int s = 0; s <= 130; s += 3) begin
      for (int e = 0; e <= 130; e += 5) begin
        run_req(s, e, 0, "R4 R5");
        run_req(s, e, 1, "R2");
        run_req(s, e, 2, "R3");
      end
    end
    for (int s = 0; s <= 96; s += 16) begin
      for (int e = s; e <= s + 70; e += 17) run_req(s, e, 3, "R3");
    end
    summary();
    $finish;
  end
endmodule